// File: doc/BRIEF.md
# Float round-to-int32-range unit

This block takes one IEEE-754 operand, either single or double precision, and rounds it to an integral value in the same format. The rounding direction comes from a 2-bit mode input. The rounded value must also lie in the signed 32-bit integer range. This limit applies whether the operand is 32 or 64 bits wide. If the result falls outside that range, or the operand is an infinity or a NaN, the output saturates to the float encoding of -2^31 and the invalid flag is raised. If the result is in range but differs numerically from the operand, the inexact flag is raised instead.

The block sits in a floating-point execute path as a single-cycle registered stage. The caller presents the operand, the format select, the mode and a valid strobe. One clock later it reads the result, the two exception flags and an undefined-format flag. A format select the block does not support produces a zero result and the undefined flag, and no exception flags.

Top module: `fri32_round_unit`

## Requirements
- R1: Format select 00 means single precision and 01 means double precision. Selects 10 and 11 give out_undef=1, a zero result, and out_invalid=out_inexact=0.
- R2: The mode input is decoded as 00 nearest-even (ties go to the even integer), 01 toward +infinity, 10 toward -infinity and 11 toward zero.
- R3: A zero operand of either sign is returned unchanged, keeping its sign, with no flags raised.
- R4: When the rounded value differs numerically from the operand and is in range, out_inexact=1 and the result is the rounded integer in the operand's format.
- R5: An infinite or NaN operand returns -2^31 in the operand's format, with out_invalid=1. In single precision this is 0xCF000000. In double precision it is 0xC1E0000000000000.
- R6: The range test uses the value after rounding. The valid range is [-2^31, 2^31-1]. A rounded value outside it returns the saturation value of R5 with out_invalid=1. For example, -2147483648.4 rounded toward zero is valid, and 2147483647.6 rounded to nearest is invalid.
- R7: out_invalid and out_inexact are never set together; an invalid result reports no inexact.
- R8: A negative operand that rounds to zero returns negative zero. A subnormal operand rounds to zero or to ±1 according to the mode, with out_inexact=1.
- R9: An operand that is already integral and in range is returned bit for bit, with no flags. This includes every value whose exponent reaches the mantissa width.
- R10: out_valid equals in_valid delayed by one clock. Reset clears out_valid, the result and all flags.
- R11: A single-precision result occupies out_result[31:0], with the upper bits zero, whatever the operand's upper bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_fmt | input | 2 | Format select: 00 single, 01 double, 1x undefined |
| in_mode | input | 2 | Rounding mode (encoding in R2) |
| in_operand | input | OP_W (64) | Operand; single precision uses bits [31:0] |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | OP_W (64) | Rounded or saturated value |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_undef | output | 1 | Unsupported format select |

## Verification
The hardest case to reach is the narrow band just past the range limit. There, the operand lies in range before rounding, and only the rounding step pushes it over or keeps it inside. Double-precision operands carry enough mantissa to sit a fraction away from ±2^31, so the stimulus uses hand-encoded values such as -2147483648.4 and 2147483647.6. Each is applied under two modes, so the same operand is seen both valid-and-inexact and saturated. Subnormal and tie inputs are applied under opposite modes for the same reason.

// File: rtl/fri_pkg.sv
package fri_pkg;

  typedef enum logic [1:0] {
    RMODE_NEAREST = 2'b00,
    RMODE_UP      = 2'b01,
    RMODE_DOWN    = 2'b10,
    RMODE_ZERO    = 2'b11
  } fri_mode_e;

  // Increment decision for a magnitude truncated at the integer point.
  function automatic logic fri_round_up(input fri_mode_e mode, input logic sgn,
                                        input logic lsb, input logic rnd,
                                        input logic stk);
    logic lost;
    lost = rnd | stk;
    case (mode)
      RMODE_NEAREST: fri_round_up = rnd & (stk | lsb);
      RMODE_UP:      fri_round_up = !sgn & lost;
      RMODE_DOWN:    fri_round_up = sgn & lost;
      default:       fri_round_up = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fri_fmt_decode.sv
module fri_fmt_decode (
  input  logic [1:0] fmt,
  output logic       sel_dp,
  output logic       undef
);
  // R1: only 00 and 01 are supported formats
  assign undef  = fmt[1];
  assign sel_dp = fmt[0];
endmodule

// File: rtl/fri_core.sv
module fri_core #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op,
  input  logic [1:0]   mode,
  output logic [W-1:0] res,
  output logic         invalid,
  output logic         inexact
);
  import fri_pkg::*;

  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int FR    = MAN_W + 2;            // fraction bits kept in window
  localparam int SW    = MAN_W + 1 + INT_W + 1;
  localparam int MAG_W = INT_W + 1;
  localparam int SH_W  = $clog2(INT_W + 2);
  localparam logic signed [EXP_W+1:0] UE_MAX = (EXP_W+2)'(INT_W - 1);
  localparam logic signed [EXP_W+1:0] UE_MIN = -(EXP_W+2)'(2);
  localparam logic [MAG_W-1:0] LIMIT = MAG_W'(1) << (INT_W - 1);
  localparam logic [W-1:0] SAT = {1'b1, EXP_W'(BIAS + INT_W - 1), MAN_W'(0)};

  // Rebuild a float from a sign and an integer magnitude.
  function automatic logic [W-1:0] pack_int(input logic s, input logic [MAG_W-1:0] m);
    int lead;
    logic [MAG_W+MAN_W-1:0] ext;
    lead = -1;
    for (int i = 0; i < MAG_W; i++) if (m[i]) lead = i;
    if (lead < 0) begin
      pack_int = {s, (W-1)'(0)};
    end else begin
      ext = {m, MAN_W'(0)} >> lead;
      pack_int = {s, EXP_W'(BIAS + lead), ext[MAN_W-1:0]};
    end
  endfunction

  logic                    sgn;
  logic [EXP_W-1:0]        ex;
  logic [MAN_W-1:0]        mn;
  logic signed [EXP_W+1:0] ue;
  logic                    is_special, is_big, is_tiny;
  logic [SH_W-1:0]         sh;
  logic [SW-1:0]           wide;
  logic [INT_W-1:0]        int_part;
  logic                    rnd_bit, stk_bit, lost, up;
  logic [MAG_W-1:0]        mag;
  logic                    out_of_range;

  assign sgn = op[W-1];
  assign ex  = op[W-2:MAN_W];
  assign mn  = op[MAN_W-1:0];
  assign ue  = $signed({2'b00, ex}) - $signed((EXP_W+2)'(BIAS));

  assign is_special = &ex;
  assign is_big     = !is_special && (ue > UE_MAX);
  assign is_tiny    = ue < UE_MIN;

  assign sh   = SH_W'(ue - UE_MIN);
  assign wide = SW'({1'b1, mn}) << sh;

  always_comb begin
    if (is_tiny) begin
      int_part = '0;
      rnd_bit  = 1'b0;
      stk_bit  = (ex != '0) || (mn != '0);
    end else begin
      int_part = wide[SW-1:FR];
      rnd_bit  = wide[FR-1];
      stk_bit  = |wide[FR-2:0];
    end
  end

  assign lost = rnd_bit | stk_bit;
  assign up   = fri_round_up(fri_mode_e'(mode), sgn, int_part[0], rnd_bit, stk_bit);
  assign mag  = {1'b0, int_part} + MAG_W'(up);

  assign out_of_range = sgn ? (mag > LIMIT) : (mag >= LIMIT);

  assign invalid = is_special | is_big | out_of_range;
  assign inexact = !invalid & lost;
  assign res     = invalid ? SAT : (inexact ? pack_int(sgn, mag) : op);
endmodule

// File: rtl/fri32_round_unit.sv
module fri32_round_unit #(
  parameter int INT_W  = 32,
  parameter int OP_W   = 64,
  parameter int SP_EXP = 8,
  parameter int SP_MAN = 23,
  parameter int DP_EXP = 11,
  parameter int DP_MAN = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_fmt,
  input  logic [1:0]      in_mode,
  input  logic [OP_W-1:0] in_operand,
  output logic            out_valid,
  output logic [OP_W-1:0] out_result,
  output logic            out_invalid,
  output logic            out_inexact,
  output logic            out_undef
);
  localparam int NFMT = 2;

  logic            sel_dp, fmt_undef;
  logic [OP_W-1:0] core_res [NFMT];
  logic [NFMT-1:0] core_inv, core_inx;
  logic [OP_W-1:0] nxt_result;
  logic            nxt_inv, nxt_inx;

  fri_fmt_decode u_dec (.fmt(in_fmt), .sel_dp(sel_dp), .undef(fmt_undef));

  for (genvar gi = 0; gi < NFMT; gi++) begin : g_fmt
    localparam int EW = (gi == 0) ? SP_EXP : DP_EXP;
    localparam int MW = (gi == 0) ? SP_MAN : DP_MAN;
    localparam int WW = 1 + EW + MW;
    logic [WW-1:0] res_w;
    fri_core #(.EXP_W(EW), .MAN_W(MW), .INT_W(INT_W)) u_core (
      .op(in_operand[WW-1:0]), .mode(in_mode), .res(res_w),
      .invalid(core_inv[gi]), .inexact(core_inx[gi]));
    assign core_res[gi] = OP_W'(res_w);
  end

  assign nxt_result = fmt_undef ? '0 : core_res[sel_dp];
  assign nxt_inv    = !fmt_undef & core_inv[sel_dp];
  assign nxt_inx    = !fmt_undef & core_inx[sel_dp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_undef   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_result;
        out_invalid <= nxt_inv;
        out_inexact <= nxt_inx;
        out_undef   <= fmt_undef;
      end
    end
  end
endmodule

// File: rtl/fri32_round_chk.sv
module fri32_round_chk #(
  parameter int OP_W = 64,
  parameter int SP_W = 32,
  parameter logic [OP_W-1:0] SAT_SP = 64'h0000_0000_CF00_0000,
  parameter logic [OP_W-1:0] SAT_DP = 64'hC1E0_0000_0000_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      in_fmt,
  input logic [OP_W-1:0] in_operand,
  input logic            out_valid,
  input logic [OP_W-1:0] out_result,
  input logic            out_invalid,
  input logic            out_inexact,
  input logic            out_undef
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid == $past(in_valid));

  assert_undef_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> !out_invalid && !out_inexact && out_result == '0);

  assert_sat_value_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid && out_invalid |-> out_result == ($past(in_fmt[0]) ? SAT_DP : SAT_SP));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_invalid, out_inexact, out_undef}));

  assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid && !out_invalid && !out_inexact && !out_undef |->
      out_result == ($past(in_fmt[0]) ? $past(in_operand)
                                       : {{(OP_W-SP_W){1'b0}}, $past(in_operand[SP_W-1:0])}));

  assert_single_upper_R11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid && !out_undef && !$past(in_fmt[0]) |-> out_result[OP_W-1:SP_W] == '0);
endmodule

bind fri32_round_unit fri32_round_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
  .in_operand(in_operand), .out_valid(out_valid), .out_result(out_result),
  .out_invalid(out_invalid), .out_inexact(out_inexact), .out_undef(out_undef));

// File: tb/tb_fri32_round_unit.sv
module tb_fri32_round_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_fmt = 2'b00;
  logic [1:0]  in_mode = 2'b00;
  logic [63:0] in_operand = '0;
  logic        out_valid, out_invalid, out_inexact, out_undef;
  logic [63:0] out_result;
  int n_total = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fri32_round_unit dut (.*);

  // {req[3:0], fmt[1:0], mode[1:0], op[63:0], exp[63:0], inv, inx, und}
  localparam int VW = 4 + 2 + 2 + 64 + 64 + 3;
  function automatic logic [VW-1:0] mk(input int req, input logic [1:0] f, input logic [1:0] m,
                                       input logic [63:0] op, input logic [63:0] ex,
                                       input logic inv, input logic inx, input logic und);
    mk = {4'(req), f, m, op, ex, inv, inx, und};
  endfunction

  localparam int NV = 32;
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(2, 0, 0, 64'h3FC00000, 64'h40000000, 0, 1, 0),   // R2 1.5 nearest -> 2
    mk(2, 0, 0, 64'h40200000, 64'h40000000, 0, 1, 0),   // R2 2.5 nearest tie -> 2
    mk(2, 0, 0, 64'h3F000000, 64'h00000000, 0, 1, 0),   // R2 0.5 nearest tie -> +0
    mk(2, 0, 1, 64'hBFC00000, 64'hBF800000, 0, 1, 0),   // R2 -1.5 up -> -1
    mk(2, 0, 2, 64'hBFC00000, 64'hC0000000, 0, 1, 0),   // R2 -1.5 down -> -2
    mk(2, 0, 3, 64'h3FC00000, 64'h3F800000, 0, 1, 0),   // R2 1.5 toward zero -> 1
    mk(4, 0, 1, 64'h3ECCCCCD, 64'h3F800000, 0, 1, 0),   // R4 0.4 up -> 1
    mk(3, 0, 0, 64'h80000000, 64'h80000000, 0, 0, 0),   // R3 -0 kept
    mk(3, 1, 1, 64'h0, 64'h0, 0, 0, 0),                 // R3 double +0 kept
    mk(8, 0, 0, 64'hBECCCCCD, 64'h80000000, 0, 1, 0),   // R8 -0.4 -> -0
    mk(8, 0, 1, 64'h00000001, 64'h3F800000, 0, 1, 0),   // R8 subnormal up -> 1
    mk(8, 0, 2, 64'h80000001, 64'hBF800000, 0, 1, 0),   // R8 -subnormal down -> -1
    mk(8, 0, 3, 64'h80000001, 64'h80000000, 0, 1, 0),   // R8 -subnormal toward zero -> -0
    mk(5, 0, 0, 64'h7F800000, 64'hCF000000, 1, 0, 0),   // R5 single +inf
    mk(5, 0, 1, 64'h7FC00000, 64'hCF000000, 1, 0, 0),   // R5 single NaN
    mk(5, 1, 3, 64'h7FF0000000000000, 64'hC1E0000000000000, 1, 0, 0), // R5 double inf
    mk(5, 1, 0, 64'hFFF8000000000000, 64'hC1E0000000000000, 1, 0, 0), // R5 double NaN
    mk(6, 0, 3, 64'h4F000000, 64'hCF000000, 1, 0, 0),   // R6 single +2^31 out
    mk(9, 0, 0, 64'hCF000000, 64'hCF000000, 0, 0, 0),   // R9 single -2^31 in range
    mk(6, 1, 3, 64'hC1E00000000CCCCD, 64'hC1E0000000000000, 0, 1, 0), // R6 -2^31-0.4 zero: ok
    mk(7, 1, 2, 64'hC1E00000000CCCCD, 64'hC1E0000000000000, 1, 0, 0), // R7 same down: invalid only
    mk(6, 1, 0, 64'h41DFFFFFFFE66666, 64'hC1E0000000000000, 1, 0, 0), // R6 2^31-0.4 nearest: out
    mk(6, 1, 3, 64'h41DFFFFFFFE66666, 64'h41DFFFFFFFC00000, 0, 1, 0), // R6 same zero: 2^31-1
    mk(6, 1, 0, 64'h4415AF1D78B58C40, 64'hC1E0000000000000, 1, 0, 0), // R6 huge double
    mk(9, 1, 2, 64'h4014000000000000, 64'h4014000000000000, 0, 0, 0), // R9 double 5.0
    mk(9, 0, 1, 64'h4EFFFFFF, 64'h4EFFFFFF, 0, 0, 0),   // R9 large single integral
    mk(11, 0, 0, 64'hDEADBEEF3F800000, 64'h3F800000, 0, 0, 0), // R11 upper bits ignored
    mk(1, 2, 0, 64'h3FC00000, 64'h0, 0, 0, 1),          // R1 select 10
    mk(1, 3, 1, 64'h7FF0000000000000, 64'h0, 0, 0, 1),  // R1 select 11
    mk(2, 1, 0, 64'h4004000000000000, 64'h4000000000000000, 0, 1, 0), // R2 double 2.5 nearest
    mk(2, 1, 1, 64'h4004000000000000, 64'h4008000000000000, 0, 1, 0), // R2 double 2.5 up
    mk(4, 1, 2, 64'hC004000000000000, 64'hC008000000000000, 0, 1, 0)  // R4 double -2.5 down
  };

  task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got res=%h inv=%b inx=%b und=%b, expected res=%h inv=%b inx=%b und=%b",
               req, act[66:3], act[2], act[1], act[0], exp[66:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b, expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [1:0] m, input logic [63:0] op);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_mode = m; in_operand = op;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", {out_result, out_invalid, out_inexact, out_undef}, '0);
    check_bit("R10 reset valid", out_valid, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(v[VW-5:VW-6], v[VW-7:VW-8], v[130:67]);
      check_bit($sformatf("R10 valid vec%0d", i), out_valid, 1'b1);
      check($sformatf("R%0d vec%0d", v[VW-1:VW-4], i),
            {out_result, out_invalid, out_inexact, out_undef}, v[66:0]);
    end

    // R10: no strobe in, no strobe out
    @(negedge clk);
    check_bit("R10 idle valid", out_valid, 1'b0);

    // R10: reset in the middle of a run clears outputs
    apply(2'b00, 2'b00, 64'h7F800000);
    check_bit("R5 pre-reset invalid", out_invalid, 1'b1);
    in_valid = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R10 mid-run reset", {out_result, out_invalid, out_inexact, out_undef}, '0);
    check_bit("R10 mid-run reset valid", out_valid, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R8: back-to-back strobes, negative half under nearest-even -> -0
    @(negedge clk);
    in_valid = 1'b1; in_fmt = 2'b00; in_mode = 2'b00; in_operand = 64'hBF000000;
    @(negedge clk);
    check("R8 -0.5 nearest", {out_result, out_invalid, out_inexact, out_undef},
          {64'h80000000, 3'b010});
    in_operand = 64'h40400000; // 3.0 integral
    @(negedge clk);
    check("R9 3.0 back-to-back", {out_result, out_invalid, out_inexact, out_undef},
          {64'h40400000, 3'b000});
    in_valid = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule